// File: doc/BRIEF.md
# Duplicated Adder with Two-Rail Error Checker

This block wraps an unsigned ripple-carry adder with concurrent error detection. Two copies of the adder receive the same operands and carry input in the same evaluation. The primary copy produces the sum and carry as usual. The twin copy produces the bitwise inverse of the same result. Each primary bit and its inverted twin form a two-rail pair. A tree of two-rail checker cells reduces all the pairs to one root pair.

The root pair is a valid code word (01 or 10) only while every leaf pair is complementary. A single error flag is derived from the root pair. Two fault masks, one for each copy, let a testbench flip any output bit of either copy. This exercises the detection path without changing the adder itself. The whole block is combinational, so a flipped bit shows on the error flag in the same evaluation.

Top module: `dup_adder_ced`

## Requirements
- R1: With both fault masks zero, `{carry_out, sum}` equals `op_a + op_b + carry_in` as an unsigned (WIDTH+1)-bit value.
- R2: Bit k of `flt_main` inverts output bit k of the primary copy. Bits 0 to WIDTH-1 map to `sum` bits 0 to WIDTH-1, and bit WIDTH maps to `carry_out`. The visible `{carry_out, sum}` is therefore the true result XOR `flt_main`.
- R3: With both masks zero, `err` is 0 for every operand and carry combination. `chk_rail` is then either 2'b01 or 2'b10.
- R4: Setting any single bit of `flt_main` while `flt_twin` is zero drives `err` to 1 in the same evaluation.
- R5: Setting any single bit of `flt_twin` while `flt_main` is zero drives `err` to 1 in the same evaluation.
- R6: For any pair of masks, `err` is 1 exactly when `flt_main` differs from `flt_twin`. Equal masks keep both copies complementary, so `err` stays 0.
- R7: `err` is 1 exactly when `chk_rail` is 2'b00 or 2'b11.
- R8: `flt_twin` never changes `sum` or `carry_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into the least significant bit |
| flt_main | input | WIDTH+1 | Fault mask XORed onto the primary copy's outputs (bit WIDTH = carry) |
| flt_twin | input | WIDTH+1 | Fault mask XORed onto the inverted twin's outputs (bit WIDTH = carry) |
| sum | output | WIDTH | Sum from the primary copy, after its fault mask |
| carry_out | output | 1 | Carry out from the primary copy, after its fault mask |
| chk_rail | output | 2 | Root two-rail pair of the checker tree, {rail1, rail0} |
| err | output | 1 | Error flag: 1 when the root pair is not a valid two-rail code word |

## Verification
Two functions can act in the same evaluation: the arithmetic result seen on `sum`/`carry_out` while a fault is injected, and the checker's verdict on that fault.

Faults on both copies at once are the most revealing case. When the same bit is flipped in both copies, the pairs stay complementary, so the flag must stay low even though `sum` is corrupted. A random phase makes the two masks equal in one draw out of three and independent otherwise. Each draw is judged against the reference sum XOR the primary mask and against an error flag expected exactly when the masks differ.

The sweep covers every operand pair, and targeted single-bit injections run on each copy for every output bit.

// File: rtl/dup_ced_pkg.sv
package dup_ced_pkg;

  // Two-rail pair: bit 0 is rail0, bit 1 is rail1. Valid words are 01 and 10.
  typedef logic [1:0] rail_t;

  // Number of nodes at tree level lv for n leaves (ceiling of n / 2^lv).
  function automatic int lvl_cnt(input int n, input int lv);
    return (n + (1 << lv) - 1) >> lv;
  endfunction

  // Index of the first node of level lv in a flat node array.
  function automatic int lvl_off(input int n, input int lv);
    int s;
    s = 0;
    for (int k = 0; k < lv; k++) s += lvl_cnt(n, k);
    return s;
  endfunction

endpackage

// File: rtl/rca_core.sv
module rca_core #(
  parameter int WIDTH      = 8,
  parameter bit INVERT_OUT = 1'b0
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             cin,
  output logic [WIDTH:0]   res
);

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] s;

  assign carry[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    logic half;
    assign half       = op_a[i] ^ op_b[i];
    assign s[i]       = half ^ carry[i];
    assign carry[i+1] = (op_a[i] & op_b[i]) | (carry[i] & half);
  end

  if (INVERT_OUT) begin : g_inv
    assign res = ~{carry[WIDTH], s};
  end else begin : g_true
    assign res = {carry[WIDTH], s};
  end

endmodule

// File: rtl/trc_cell.sv
module trc_cell
  import dup_ced_pkg::*;
(
  input  rail_t x,
  input  rail_t y,
  output rail_t z
);

  assign z[0] = (x[0] & y[0]) | (x[1] & y[1]);
  assign z[1] = (x[0] & y[1]) | (x[1] & y[0]);

endmodule

// File: rtl/trc_tree.sv
module trc_tree
  import dup_ced_pkg::*;
#(
  parameter int LEAVES = 9
) (
  input  logic [LEAVES-1:0] rail0,
  input  logic [LEAVES-1:0] rail1,
  output rail_t             root
);

  localparam int DEPTH = $clog2(LEAVES);
  localparam int NODES = lvl_off(LEAVES, DEPTH + 1);

  rail_t node [NODES];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    assign node[i] = {rail1[i], rail0[i]};
  end

  for (genvar lv = 0; lv < DEPTH; lv++) begin : g_lvl
    localparam int CUR = lvl_cnt(LEAVES, lv);
    localparam int NXT = lvl_cnt(LEAVES, lv + 1);
    localparam int OC  = lvl_off(LEAVES, lv);
    localparam int ON  = lvl_off(LEAVES, lv + 1);
    for (genvar j = 0; j < NXT; j++) begin : g_node
      if (2 * j + 1 < CUR) begin : g_cell
        trc_cell u_cell (
          .x (node[OC + 2*j]),
          .y (node[OC + 2*j + 1]),
          .z (node[ON + j])
        );
      end else begin : g_pass
        assign node[ON + j] = node[OC + 2*j];
      end
    end
  end

  assign root = node[NODES-1];

endmodule

// File: rtl/dup_adder_ced.sv
module dup_adder_ced
  import dup_ced_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  input  logic [WIDTH:0]   flt_main,
  input  logic [WIDTH:0]   flt_twin,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic [1:0]       chk_rail,
  output logic             err
);

  localparam int OUTS = WIDTH + 1;

  logic [OUTS-1:0] main_raw, twin_raw;
  logic [OUTS-1:0] main_obs, twin_obs;
  rail_t           root;

  rca_core #(.WIDTH(WIDTH), .INVERT_OUT(1'b0)) u_main (
    .op_a (op_a), .op_b (op_b), .cin (carry_in), .res (main_raw)
  );

  rca_core #(.WIDTH(WIDTH), .INVERT_OUT(1'b1)) u_twin (
    .op_a (op_a), .op_b (op_b), .cin (carry_in), .res (twin_raw)
  );

  assign main_obs = main_raw ^ flt_main;
  assign twin_obs = twin_raw ^ flt_twin;

  trc_tree #(.LEAVES(OUTS)) u_tree (
    .rail0 (main_obs),
    .rail1 (twin_obs),
    .root  (root)
  );

  assign sum       = main_obs[WIDTH-1:0];
  assign carry_out = main_obs[WIDTH];
  assign chk_rail  = root;
  assign err       = ~(root[0] ^ root[1]);

endmodule

// File: rtl/dup_adder_ced_chk.sv
module dup_adder_ced_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic [WIDTH:0]   flt_main,
  input logic [WIDTH:0]   flt_twin,
  input logic [WIDTH-1:0] sum,
  input logic             carry_out,
  input logic [1:0]       chk_rail,
  input logic             err
);

  logic [WIDTH:0] ref_res;
  assign ref_res = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};

  // R1 and R2: visible result is the true sum XOR the primary mask
  always_comb begin
    a_r2_main_mask: assert ({carry_out, sum} == (ref_res ^ flt_main))
      else $error("a_r2_main_mask");
  end

  // R6: error exactly when the masks differ
  always_comb begin
    a_r6_err_iff_diff: assert (err == (flt_main != flt_twin))
      else $error("a_r6_err_iff_diff");
  end

  // R3: clean operation gives a valid root word
  always_comb begin
    if (flt_main == flt_twin) begin
      a_r3_clean_valid: assert (chk_rail == 2'b01 || chk_rail == 2'b10)
        else $error("a_r3_clean_valid");
    end
  end

  // R4 and R5: a single flipped bit on one copy is flagged
  always_comb begin
    if ($countones(flt_main ^ flt_twin) == 1) begin
      a_r4_single_flip: assert (err)
        else $error("a_r4_single_flip");
    end
  end

endmodule

bind dup_adder_ced dup_adder_ced_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .carry_in  (carry_in),
  .flt_main  (flt_main),
  .flt_twin  (flt_twin),
  .sum       (sum),
  .carry_out (carry_out),
  .chk_rail  (chk_rail),
  .err       (err)
);

// File: tb/test_dup_adder_ced.sv
`timescale 1ns/1ps
module test_dup_adder_ced;

  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] op_a, op_b;
  logic         carry_in;
  logic [W:0]   flt_main, flt_twin;
  logic [W-1:0] sum;
  logic         carry_out;
  logic [1:0]   chk_rail;
  logic         err;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  dup_adder_ced #(.WIDTH(W)) i_dup_adder_ced (
    .op_a (op_a), .op_b (op_b), .carry_in (carry_in),
    .flt_main (flt_main), .flt_twin (flt_twin),
    .sum (sum), .carry_out (carry_out), .chk_rail (chk_rail), .err (err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic c, input logic [W:0] fm, input logic [W:0] ft);
    @(posedge clk);
    op_a = a; op_b = b; carry_in = c; flt_main = fm; flt_twin = ft;
    @(negedge clk);
  endtask

  function automatic logic [W:0] ref_add(input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  function automatic logic [31:0] step(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic bit rail_ok(input logic [1:0] r);
    return (r == 2'b01) || (r == 2'b10);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    op_a = '0; op_b = '0; carry_in = 1'b0; flt_main = '0; flt_twin = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check({carry_out, sum} == '0, "R1", "reset sum", {carry_out, sum}, 0);
    check(err == 1'b0, "R3", "reset err", err, 0);
    @(posedge clk);
    rst_n = 1'b1;

    // Exhaustive clean sweep over all operand pairs
    for (int ia = 0; ia < 256; ia++) begin
      for (int ib = 0; ib < 256; ib++) begin
        logic c;
        logic [W:0] e;
        c = ia[0] ^ ib[1];
        e = ref_add(ia[W-1:0], ib[W-1:0], c);
        apply(ia[W-1:0], ib[W-1:0], c, '0, '0);
        check({carry_out, sum} == e, "R1", "clean sum", {carry_out, sum}, e);
        check(err == 1'b0, "R3", "clean err", err, 0);
        check(rail_ok(chk_rail), "R3", "clean rail", chk_rail, 1);
      end
    end

    // Single-bit injections on each copy
    for (int k = 0; k < 64; k++) begin
      logic [W-1:0] a, b;
      logic c;
      logic [W:0] e;
      a = W'((k * 37 + 5) % 256);
      b = W'((k * 91 + 3) % 256);
      c = k[0];
      e = ref_add(a, b, c);
      for (int bit_i = 0; bit_i <= W; bit_i++) begin
        logic [W:0] m;
        m = (W+1)'(1) << bit_i;
        apply(a, b, c, m, '0);
        check(err == 1'b1, "R4", "main flip err", err, 1);
        check({carry_out, sum} == (e ^ m), "R2", "main flip sum",
              {carry_out, sum}, e ^ m);
        check(!rail_ok(chk_rail), "R7", "main flip rail", chk_rail, 0);
        apply(a, b, c, '0, m);
        check(err == 1'b1, "R5", "twin flip err", err, 1);
        check({carry_out, sum} == e, "R8", "twin flip sum", {carry_out, sum}, e);
      end
    end

    // Random mask pairs, equal in one draw of three
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] a, b;
      logic c;
      logic [W:0] fm, ft, e;
      lfsr = step(lfsr); a = lfsr[7:0]; b = lfsr[15:8]; c = lfsr[16];
      lfsr = step(lfsr); fm = lfsr[W:0];
      lfsr = step(lfsr); ft = (n % 3 == 0) ? fm : lfsr[W:0];
      e = ref_add(a, b, c);
      apply(a, b, c, fm, ft);
      check(err == (fm != ft), "R6", "mask pair err", err, fm != ft);
      check({carry_out, sum} == (e ^ fm), "R2", "mask pair sum",
            {carry_out, sum}, e ^ fm);
      check(err == !rail_ok(chk_rail), "R7", "rail vs err", chk_rail, err);
    end

    finish_run();
  end

endmodule